// File: doc/BRIEF.md
# Priority Grouping Preemption Comparator

This unit decides whether a pending interrupt is allowed to interrupt the handler that is currently running. Each 8-bit priority is split at a programmable binary point. A 3-bit grouping selector places that point. The bits above the point form the group priority and the bits below it form the subpriority. Only the group part takes part in the preemption decision. Two requests in the same group therefore never interrupt each other, whatever their subpriorities are.

A request is presented with `inValid` together with the pending priority, the active priority, a flag saying whether any handler is running, and the grouping selector. One clock later the unit raises `outValid` for a single cycle. At that point it presents the preemption verdict and, as helpers, the right-justified group value and the subpriority value of the pending priority. A parameter sets how many high-order priority bits are implemented. The unimplemented low bits of both priorities are forced to zero before the split.

Top module: `prio_preempt_cmp`

## Requirements
- R1: While `rstN` is low, `outValid`, `mayPreempt`, `pendGroup` and `pendSub` are all zero.
- R2: Results appear one clock after a cycle with `inValid` high, and `outValid` is high in exactly that following cycle. After a cycle with `inValid` low, `outValid` is low.
- R3: In a cycle that follows one with `inValid` low, `mayPreempt`, `pendGroup` and `pendSub` keep their previous values, even when the other inputs change.
- R4: For a selector value g from 0 to 6, `pendGroup` equals pending priority bits [7:g+1], shifted down to bit 0 with zeros above. `pendSub` equals bits [g:0] with zeros above.
- R5: For selector value 7, `pendGroup` is 0 and `pendSub` is the whole masked priority. Every request then falls into one group, so a running handler is never preempted.
- R6: With `anyActive` high, `mayPreempt` is 1 exactly when the pending group value is numerically smaller than the active group value. A smaller value means more urgent.
- R7: With `anyActive` high, two priorities whose group values are equal give `mayPreempt` = 0, whatever their subpriorities are.
- R8: With `anyActive` low, `mayPreempt` is 1 for any pending priority and any selector.
- R9: With parameter `IMPL_BITS` = n, priority bits [7-n:0] of both inputs are treated as zero before the split and the comparison. As a result, `pendSub` never shows those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A request is presented this cycle |
| pendPrio | input | 8 | Priority of the pending interrupt |
| activePrio | input | 8 | Priority of the running handler |
| anyActive | input | 1 | High when some handler is running |
| groupSel | input | 3 | Binary point position selector |
| outValid | output | 1 | Result registers were loaded on the last edge |
| mayPreempt | output | 1 | Pending interrupt may proceed |
| pendGroup | output | 8 | Right-justified group value of the pending priority |
| pendSub | output | 8 | Subpriority value of the pending priority |

## Verification
The bench builds two copies of the block side by side on the same stimulus. One copy uses the default of eight implemented bits, so every binary point position and every sub/group boundary can be reached. The other copy uses `IMPL_BITS` = 4, which brings the low-bit masking within reach. On that copy, the points at positions 0 to 3 leave an all-zero subpriority, and pairs that differ only in masked bits must compare as equal groups. The selector is swept over all eight values against random priority pairs. Directed pairs sit exactly on group boundaries.

// File: rtl/prio_split_pkg.sv
package prio_split_pkg;
  localparam int PRIO_W  = 8;
  localparam int SEL_W   = $clog2(PRIO_W);
  localparam int SHIFT_W = SEL_W + 1;

  typedef logic [PRIO_W-1:0] prio_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               load;
    logic               noGroup;
    logic [SHIFT_W-1:0] shiftAmt;
    prio_t              subMask;
  } splitCtl_t;
endpackage

// File: rtl/prio_split_ctrl.sv
module prio_split_ctrl
  import prio_split_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SEL_W-1:0] groupSel,
  output splitCtl_t        ctl,
  output logic             outValid
);
  localparam logic [SEL_W-1:0] ALL_SUB = '1;

  logic [PRIO_W-1:0] maskBits;

  // a bit belongs to the subpriority when its index is at or below the point
  for (genvar i = 0; i < PRIO_W; i++) begin : g_mask
    assign maskBits[i] = (SHIFT_W'(i) <= {1'b0, groupSel});
  end

  always_comb begin
    ctl.load     = inValid;
    ctl.noGroup  = (groupSel == ALL_SUB);
    ctl.shiftAmt = {1'b0, groupSel} + SHIFT_W'(1);
    ctl.subMask  = maskBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/prio_field_split.sv
module prio_field_split
  import prio_split_pkg::*;
#(
  parameter int IMPL_BITS = 8
) (
  input  prio_t     rawPrio,
  input  splitCtl_t ctl,
  output prio_t     groupVal,
  output prio_t     subVal
);
  localparam int DROP_BITS = PRIO_W - IMPL_BITS;

  prio_t implMask;
  prio_t masked;

  // zero the unimplemented low bits
  for (genvar i = 0; i < PRIO_W; i++) begin : g_impl
    if (i < DROP_BITS) begin : g_drop
      assign implMask[i] = 1'b0;
    end else begin : g_keep
      assign implMask[i] = 1'b1;
    end
  end

  always_comb begin
    masked   = rawPrio & implMask;
    groupVal = ctl.noGroup ? '0 : (masked >> ctl.shiftAmt);
    subVal   = masked & ctl.subMask;
  end
endmodule

// File: rtl/prio_split_dp.sv
module prio_split_dp
  import prio_split_pkg::*;
#(
  parameter int IMPL_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  splitCtl_t ctl,
  input  prio_t     pendPrio,
  input  prio_t     activePrio,
  input  logic      anyActive,
  output logic      mayPreempt,
  output prio_t     pendGroup,
  output prio_t     pendSub
);
  prio_t pendGrpC, pendSubC, actGrpC, actSubC;
  logic  preemptC;

  prio_field_split #(.IMPL_BITS(IMPL_BITS)) u_pendSplit (
    .rawPrio (pendPrio),
    .ctl     (ctl),
    .groupVal(pendGrpC),
    .subVal  (pendSubC)
  );

  prio_field_split #(.IMPL_BITS(IMPL_BITS)) u_actSplit (
    .rawPrio (activePrio),
    .ctl     (ctl),
    .groupVal(actGrpC),
    .subVal  (actSubC)
  );

  // strictly more urgent group wins; idle core accepts anything
  always_comb preemptC = !anyActive || (pendGrpC < actGrpC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mayPreempt <= 1'b0;
      pendGroup  <= '0;
      pendSub    <= '0;
    end else if (ctl.load) begin
      mayPreempt <= preemptC;
      pendGroup  <= pendGrpC;
      pendSub    <= pendSubC;
    end
  end

  logic unusedSub;
  assign unusedSub = ^actSubC;
endmodule

// File: rtl/prio_preempt_cmp.sv
module prio_preempt_cmp
  import prio_split_pkg::*;
#(
  parameter int IMPL_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] pendPrio,
  input  logic [7:0] activePrio,
  input  logic       anyActive,
  input  logic [2:0] groupSel,
  output logic       outValid,
  output logic       mayPreempt,
  output logic [7:0] pendGroup,
  output logic [7:0] pendSub
);
  splitCtl_t ctl;

  prio_split_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .groupSel(groupSel),
    .ctl     (ctl),
    .outValid(outValid)
  );

  prio_split_dp #(.IMPL_BITS(IMPL_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .pendPrio  (pendPrio),
    .activePrio(activePrio),
    .anyActive (anyActive),
    .mayPreempt(mayPreempt),
    .pendGroup (pendGroup),
    .pendSub   (pendSub)
  );
endmodule

// File: rtl/prio_preempt_cmp_chk.sv
module prio_preempt_cmp_chk
  import prio_split_pkg::*;
#(
  parameter int IMPL_BITS = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] pendPrio,
  input logic [7:0] activePrio,
  input logic       anyActive,
  input logic [2:0] groupSel,
  input logic       outValid,
  input logic       mayPreempt,
  input logic [7:0] pendGroup,
  input logic [7:0] pendSub
);
  localparam prio_t LOW_MASK = prio_t'((1 << (PRIO_W - IMPL_BITS)) - 1);

  logic [2:0] selQ;
  prio_t      pendQ;
  prio_t      rebuilt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      pendQ <= '0;
    end else if (inValid) begin
      selQ  <= groupSel;
      pendQ <= pendPrio;
    end
  end

  always_comb rebuilt = prio_t'(pendGroup << ({1'b0, selQ} + 4'd1)) | pendSub;

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(mayPreempt) && $stable(pendGroup) && $stable(pendSub)));
  // R4
  split_rebuild_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (rebuilt == (pendQ & ~LOW_MASK)));
  // R5
  single_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && anyActive && groupSel == 3'd7) |=> (!mayPreempt && pendGroup == 8'd0));
  // R7
  equal_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && anyActive && pendPrio == activePrio) |=> !mayPreempt);
  // R8
  idle_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !anyActive) |=> mayPreempt);
  // R9
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((pendSub & LOW_MASK) == 8'd0));
endmodule

bind prio_preempt_cmp prio_preempt_cmp_chk #(.IMPL_BITS(IMPL_BITS)) u_chk (.*);

// File: tb/prio_preempt_cmp_tb.sv
module prio_preempt_cmp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NARROW     = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] pendPrio = '0, activePrio = '0;
  logic       anyActive = 1'b0;
  logic [2:0] groupSel = '0;

  logic       wValid, wMay, nValid, nMay;
  logic [7:0] wGroup, wSub, nGroup, nSub;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_preempt_cmp #(.IMPL_BITS(8)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pendPrio(pendPrio),
    .activePrio(activePrio), .anyActive(anyActive), .groupSel(groupSel),
    .outValid(wValid), .mayPreempt(wMay), .pendGroup(wGroup), .pendSub(wSub));

  prio_preempt_cmp #(.IMPL_BITS(NARROW)) u_dutNarrow (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pendPrio(pendPrio),
    .activePrio(activePrio), .anyActive(anyActive), .groupSel(groupSel),
    .outValid(nValid), .mayPreempt(nMay), .pendGroup(nGroup), .pendSub(nSub));

  function automatic logic [7:0] refMask(input logic [7:0] p, input int impl);
    return p & ~8'((1 << (8 - impl)) - 1);
  endfunction

  function automatic logic [7:0] refGroup(input logic [7:0] p, input logic [2:0] g, input int impl);
    if (g == 3'd7) return 8'd0;
    return refMask(p, impl) >> (int'(g) + 1);
  endfunction

  function automatic logic [7:0] refSub(input logic [7:0] p, input logic [2:0] g, input int impl);
    return refMask(p, impl) & 8'((1 << (int'(g) + 1)) - 1);
  endfunction

  function automatic logic refPre(input logic [7:0] p, a, input logic any,
                                  input logic [2:0] g, input int impl);
    if (!any) return 1'b1;
    return refGroup(p, g, impl) < refGroup(a, g, impl);
  endfunction

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (pend=%0h act=%0h any=%0b g=%0d)",
               req, act, exp, pendPrio, activePrio, anyActive, groupSel);
    end
  endtask

  logic [7:0] lastP, lastA;
  logic       lastAny;
  logic [2:0] lastG;

  task automatic runOne(input logic [7:0] p, a, input logic any, input logic [2:0] g,
                        input string req);
    @(negedge clk);
    pendPrio = p; activePrio = a; anyActive = any; groupSel = g; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chkEq({req, " R2 valid"}, wValid, 1);
    chkEq({req, " preempt"}, wMay, refPre(p, a, any, g, 8));
    chkEq({req, " R4 group"}, wGroup, refGroup(p, g, 8));
    chkEq({req, " R4 sub"}, wSub, refSub(p, g, 8));
    chkEq({req, " R9 narrow preempt"}, nMay, refPre(p, a, any, g, NARROW));
    chkEq({req, " R9 narrow group"}, nGroup, refGroup(p, g, NARROW));
    chkEq({req, " R9 narrow sub"}, nSub, refSub(p, g, NARROW));
    lastP = p; lastA = a; lastAny = any; lastG = g;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chkEq("R1 valid", wValid, 0);
    chkEq("R1 preempt", wMay, 0);
    chkEq("R1 group", wGroup, 0);
    chkEq("R1 sub", wSub, 0);
    rstN = 1'b1;

    // directed corners
    runOne(8'h40, 8'h60, 1'b1, 3'd4, "R6 smaller group");
    runOne(8'h60, 8'h40, 1'b1, 3'd4, "R6 larger group");
    runOne(8'h41, 8'h5F, 1'b1, 3'd4, "R7 same group diff sub");
    runOne(8'h80, 8'h81, 1'b1, 3'd0, "R7 boundary g0");
    runOne(8'h00, 8'hFF, 1'b1, 3'd7, "R5 one group");
    runOne(8'hFF, 8'h00, 1'b0, 3'd2, "R8 idle");
    runOne(8'hFF, 8'h00, 1'b0, 3'd7, "R8 idle g7");
    runOne(8'h21, 8'h2E, 1'b1, 3'd0, "R9 low bits only");
    runOne(8'h7F, 8'h80, 1'b1, 3'd6, "R4 top bit split");

    // R3 hold: change inputs without inValid
    @(negedge clk);
    pendPrio = ~lastP; activePrio = ~lastA; anyActive = ~lastAny; groupSel = ~lastG;
    @(negedge clk);
    chkEq("R2 valid low", wValid, 0);
    chkEq("R3 hold preempt", wMay, refPre(lastP, lastA, lastAny, lastG, 8));
    chkEq("R3 hold group", wGroup, refGroup(lastP, lastG, 8));
    chkEq("R3 hold sub", wSub, refSub(lastP, lastG, 8));

    // random sweep over every grouping value
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 40; k++) begin
        logic [7:0] p, a;
        p = 8'($urandom);
        a = (k % 4 == 0) ? (p ^ 8'($urandom_range(0, 3))) : 8'($urandom);
        runOne(p, a, ($urandom_range(0, 7) != 0), 3'(g), "R6 random");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule